// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This block is a small multicycle 16-bit processor whose arithmetic never names a register or a memory operand. It keeps an eight-entry operand stack in flip-flops. A push instruction copies a memory word onto the top of that stack. A pop instruction stores the top entry to memory and discards it. An add instruction consumes the two topmost entries and leaves their 16-bit sum in their place. A halt instruction ends the program. Instructions and data share one 128-byte space. The core reaches that space through a single word-wide synchronous port, and read data returns on the cycle after the request.

After reset the core starts fetching at byte 0. It runs until it meets a halt instruction or detects a fault, and then it stops for good. A fault is a stack overflow, a stack underflow or a malformed instruction word. It raises a sticky error flag and stops the core. Words are stored little-endian at even byte addresses. Each instruction occupies one such word, and the program counter steps by two.

Top module: `stackcore`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `done` and `err` are low. That first cycle is an instruction fetch from byte address 0.
- R2: A fetch drives `mem_rd` with `mem_addr` equal to the program counter. The counter advances by 2, modulo 128. The instruction word is decoded as follows: opcode in bits [15:13], operand address in bits [6:0], bits [12:7] reserved. Opcodes are 000 halt, 001 push, 010 pop, 011 add.
- R3: A push reads the word at its operand address in the cycle after the fetch. In the cycle after that it places the returned word on top of the stack.
- R4: A pop writes the top entry to its operand address in the cycle after the fetch and removes it. Entries leave the stack in last-in, first-out order.
- R5: An add makes no memory access. It replaces the two top entries with their sum modulo 2^16.
- R6: A halt raises `done`. From then on `done` stays high and the core makes no memory access.
- R7: A push while the stack holds 8 entries issues no read. It raises `err` and stops the core.
- R8: A pop on an empty stack, or an add with fewer than two entries, makes no write and leaves memory unchanged. It raises `err` and stops the core.
- R9: Any of the following raises `err` and stops the core without a memory access: opcode 100 to 111, non-zero reserved bits [12:7], an odd operand address on push or pop, or a non-zero address field on add or halt.
- R10: A push takes 3 cycles. Pop, add and halt take 2 cycles, counted from the fetch. `done` or `err` rises in the cycle after the executing cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 7 | Byte address of the current memory access (always even) |
| mem_rd | output | 1 | Read request; the word returns on `mem_rdata` next cycle |
| mem_wr | output | 1 | Write request for `mem_wdata` at `mem_addr` this cycle |
| mem_wdata | output | 16 | Word to be written (current top of stack) |
| mem_rdata | input | 16 | Word read in the previous cycle |
| done | output | 1 | Sticky: a halt instruction was executed |
| err | output | 1 | Sticky: overflow, underflow or malformed instruction |

## Verification
A corrupted stack pointer or entry stays hidden until the next pop. At that point it shows up at once as a wrong `mem_wdata` in the cycle that writes. It can also appear as an `err` that the reference stack does not predict. A wrong control state shows up within one cycle, as a read, a write or an address that the reference sequence does not expect. The bench therefore compares the memory strobes, the address, the write data and both flags in every cycle. It also checks the final memory contents and the total cycle count of each program.

// File: rtl/stackcore_pkg.sv
// Shared types for the stack core: opcode values, stack commands, control states.
// Assumes a 3-bit opcode field at the top of every instruction word.
package stackcore_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_HALT = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_ADD  = 3'd3
    } op_e;

    typedef enum logic [1:0] {
        STK_NONE,
        STK_PUSH,
        STK_POP,
        STK_ADD
    } stk_cmd_e;

    typedef enum logic [1:0] {
        S_FETCH,
        S_EXEC,
        S_LOAD,
        S_STOP
    } state_e;
endpackage

// File: rtl/stackcore_decode.sv
// Instruction decoder: splits a word into opcode and address and judges its form.
// Assumes opcode at the top, address at the bottom, reserved bits between must be zero.
module stackcore_decode
    import stackcore_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 7
) (
    input  logic [DATA_W-1:0] instr,
    output op_e               op,
    output logic [ADDR_W-1:0] addr,
    output logic              well_formed
);
    localparam int RSV_W = DATA_W - OP_W - ADDR_W;

    logic [OP_W-1:0]  raw_op;
    logic [RSV_W-1:0] rsv;

    assign raw_op = instr[DATA_W-1 -: OP_W];
    assign rsv    = instr[ADDR_W +: RSV_W];
    assign addr   = instr[ADDR_W-1:0];
    assign op     = op_e'(raw_op);

    // Legal opcode, clean reserved field, and an address field that suits the opcode.
    always_comb begin
        well_formed = (rsv == '0);
        case (raw_op)
            OP_PUSH, OP_POP: well_formed = well_formed && !addr[0];
            OP_ADD, OP_HALT: well_formed = well_formed && (addr == '0);
            default:         well_formed = 1'b0;
        endcase
    end
endmodule

// File: rtl/stackcore_stack.sv
// Operand stack in flip-flops with push, pop and add-in-place commands.
// Assumes the caller never issues a command that the current depth cannot serve.
module stackcore_stack
    import stackcore_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_cmd_e          cmd,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] tos,
    output logic [DATA_W-1:0] nos,
    output logic [CNT_W-1:0]  count
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] ent_q [DEPTH];
    logic [IDX_W-1:0]  top_idx;
    logic [IDX_W-1:0]  sec_idx;
    logic [IDX_W-1:0]  free_idx;
    logic [DATA_W-1:0] sum;

    assign free_idx = IDX_W'(count);
    assign top_idx  = IDX_W'(count - CNT_W'(1));
    assign sec_idx  = IDX_W'(count - CNT_W'(2));
    assign tos      = ent_q[top_idx];
    assign nos      = ent_q[sec_idx];
    assign sum      = tos + nos;

    // Entry storage: push fills the free slot, add overwrites the second entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (cmd == STK_PUSH && free_idx == IDX_W'(i)) begin
                ent_q[i] <= push_data;
            end else if (cmd == STK_ADD && sec_idx == IDX_W'(i)) begin
                ent_q[i] <= sum;
            end
        end
    end

    // Depth counter: up on push, down on pop and add.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case (cmd)
                STK_PUSH:         count <= count + CNT_W'(1);
                STK_POP, STK_ADD: count <= count - CNT_W'(1);
                default:          count <= count;
            endcase
        end
    end
endmodule

// File: rtl/stackcore.sv
// Multicycle stack processor: fetch, execute, and a load cycle for push.
// Assumes memory answers a read one cycle after mem_rd and holds mem_rdata until the next read.
module stackcore
    import stackcore_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 7,
    parameter int STACK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              err
);
    localparam int CNT_W = $clog2(STACK_DEPTH + 1);

    state_e            state_q, state_d;
    logic [ADDR_W-1:0] pc_q;
    logic              pc_inc;
    logic              set_done, set_err;
    op_e               dec_op;
    logic [ADDR_W-1:0] dec_addr;
    logic              dec_ok;
    stk_cmd_e          stk_cmd;
    logic [DATA_W-1:0] stk_tos, stk_nos;
    logic [CNT_W-1:0]  stk_count;
    logic              stk_full;

    stackcore_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
        .instr       (mem_rdata),
        .op          (dec_op),
        .addr        (dec_addr),
        .well_formed (dec_ok)
    );

    stackcore_stack #(.DATA_W(DATA_W), .DEPTH(STACK_DEPTH), .CNT_W(CNT_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (stk_cmd),
        .push_data (mem_rdata),
        .tos       (stk_tos),
        .nos       (stk_nos),
        .count     (stk_count)
    );

    assign stk_full  = (stk_count == CNT_W'(STACK_DEPTH));
    assign mem_wdata = stk_tos;

    // Next-state, memory strobes and stack command for the current phase.
    always_comb begin
        state_d  = state_q;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        mem_addr = dec_addr;
        stk_cmd  = STK_NONE;
        pc_inc   = 1'b0;
        set_done = 1'b0;
        set_err  = 1'b0;
        case (state_q)
            S_FETCH: begin
                mem_rd   = 1'b1;
                mem_addr = pc_q;
                pc_inc   = 1'b1;
                state_d  = S_EXEC;
            end
            S_EXEC: begin
                state_d = S_FETCH;
                if (!dec_ok) begin
                    set_err = 1'b1;
                    state_d = S_STOP;
                end else begin
                    case (dec_op)
                        OP_PUSH: begin
                            if (stk_full) begin
                                set_err = 1'b1;
                                state_d = S_STOP;
                            end else begin
                                mem_rd  = 1'b1;
                                state_d = S_LOAD;
                            end
                        end
                        OP_POP: begin
                            if (stk_count == '0) begin
                                set_err = 1'b1;
                                state_d = S_STOP;
                            end else begin
                                mem_wr  = 1'b1;
                                stk_cmd = STK_POP;
                            end
                        end
                        OP_ADD: begin
                            if (stk_count < CNT_W'(2)) begin
                                set_err = 1'b1;
                                state_d = S_STOP;
                            end else begin
                                stk_cmd = STK_ADD;
                            end
                        end
                        default: begin
                            set_done = 1'b1;
                            state_d  = S_STOP;
                        end
                    endcase
                end
            end
            S_LOAD: begin
                stk_cmd = STK_PUSH;
                state_d = S_FETCH;
            end
            default: state_d = S_STOP;
        endcase
    end

    // Control state, program counter and the two sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_FETCH;
            pc_q    <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (pc_inc) begin
                pc_q <= pc_q + ADDR_W'(2);
            end
            if (set_done) begin
                done <= 1'b1;
            end
            if (set_err) begin
                err <= 1'b1;
            end
        end
    end

    logic unused_nos;
    assign unused_nos = ^stk_nos;
endmodule

// File: rtl/stackcore_chk.sv
// Protocol checker for the stack core, bound onto every instance of it.
// Assumes depth is the core's internal stack occupancy.
module stackcore_chk #(
    parameter int ADDR_W = 7,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              done,
    input logic              err,
    input logic [CNT_W-1:0]  depth
);
    p_one_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_even_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !mem_addr[0]);

    p_pop_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> depth == $past(depth) - CNT_W'(1));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CNT_W'(DEPTH));

    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_stopped_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !mem_rd && !mem_wr);

    p_single_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
endmodule

bind stackcore stackcore_chk #(.ADDR_W(ADDR_W), .DEPTH(STACK_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .done     (done),
    .err      (err),
    .depth    (stk_count)
);

// File: tb/stackcore_bench.sv
// Bench: byte memory model, a behavioural per-cycle reference, and directed programs.
module stackcore_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        done, err;

    int n_checks = 0;
    int n_errs   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    stackcore u_stackcore (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done), .err(err)
    );

    // Memory: 128 bytes, little-endian words at even addresses.
    logic [7:0] m [128];

    function automatic logic [15:0] word(input logic [6:0] a);
        return {m[{a[6:1], 1'b1}], m[{a[6:1], 1'b0}]};
    endfunction

    task automatic put(input logic [6:0] a, input logic [15:0] v);
        m[{a[6:1], 1'b0}] = v[7:0];
        m[{a[6:1], 1'b1}] = v[15:8];
    endtask

    function automatic logic [15:0] enc(input logic [2:0] op, input logic [6:0] a);
        return {op, 6'd0, a};
    endfunction

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= word(mem_addr);
        if (mem_wr) put(mem_addr, mem_wdata);
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model state.
    localparam int PH_FETCH = 0, PH_EXEC = 1, PH_LOAD = 2, PH_STOP = 3;
    int          r_phase;
    logic [6:0]  r_pc;
    logic [15:0] r_ir;
    logic [6:0]  r_a;
    logic [15:0] stk [$];
    bit          r_done, r_err, ref_on = 1'b0;
    string       r_etag = "R9";

    task automatic chk_bus(input string tag, input bit e_rd, input bit e_wr,
                           input logic [6:0] e_addr, input logic [15:0] e_wd);
        logic [63:0] act, exp;
        bit ok;
        act = {38'd0, mem_rd, mem_wr, 1'b0, mem_addr, mem_wdata};
        exp = {38'd0, e_rd, e_wr, 1'b0, e_addr, e_wd};
        ok  = (mem_rd == e_rd) && (mem_wr == e_wr);
        if (e_rd || e_wr) ok = ok && (mem_addr == e_addr);
        if (e_wr) ok = ok && (mem_wdata == e_wd);
        chk(ok, tag, act, exp);
    endtask

    // Per-cycle comparison against the reference, then the reference steps.
    always @(negedge clk) begin
        if (ref_on) begin
            logic [2:0] op;
            logic [5:0] rsv;
            logic [6:0] a;
            logic [15:0] x, y;
            bit bad;
            chk(done == r_done, "R6", 64'(done), 64'(r_done));
            chk(err == r_err, r_etag, 64'(err), 64'(r_err));
            case (r_phase)
                PH_FETCH: begin
                    chk_bus("R2", 1'b1, 1'b0, r_pc, 16'h0);
                    r_ir    = word(r_pc);
                    r_pc    = r_pc + 7'd2;
                    r_phase = PH_EXEC;
                end
                PH_EXEC: begin
                    op  = r_ir[15:13];
                    rsv = r_ir[12:7];
                    a   = r_ir[6:0];
                    bad = (op > 3'd3) || (rsv != 0) ||
                          (((op == 3'd1) || (op == 3'd2)) ? a[0] : (a != 0));
                    r_phase = PH_FETCH;
                    if (bad) begin
                        chk_bus("R9", 1'b0, 1'b0, a, 16'h0);
                        r_etag = "R9"; r_err = 1'b1; r_phase = PH_STOP;
                    end else if (op == 3'd0) begin
                        chk_bus("R6", 1'b0, 1'b0, a, 16'h0);
                        r_done = 1'b1; r_phase = PH_STOP;
                    end else if (op == 3'd1) begin
                        if (stk.size() >= 8) begin
                            chk_bus("R7", 1'b0, 1'b0, a, 16'h0);
                            r_etag = "R7"; r_err = 1'b1; r_phase = PH_STOP;
                        end else begin
                            chk_bus("R3", 1'b1, 1'b0, a, 16'h0);
                            r_a = a; r_phase = PH_LOAD;
                        end
                    end else if (op == 3'd2) begin
                        if (stk.size() == 0) begin
                            chk_bus("R8", 1'b0, 1'b0, a, 16'h0);
                            r_etag = "R8"; r_err = 1'b1; r_phase = PH_STOP;
                        end else begin
                            chk_bus("R4", 1'b0, 1'b1, a, stk[$]);
                            void'(stk.pop_back());
                        end
                    end else begin
                        if (stk.size() < 2) begin
                            chk_bus("R8", 1'b0, 1'b0, a, 16'h0);
                            r_etag = "R8"; r_err = 1'b1; r_phase = PH_STOP;
                        end else begin
                            chk_bus("R5", 1'b0, 1'b0, a, 16'h0);
                            x = stk.pop_back();
                            y = stk.pop_back();
                            stk.push_back(x + y);
                        end
                    end
                end
                PH_LOAD: begin
                    chk_bus("R3", 1'b0, 1'b0, 7'd0, 16'h0);
                    stk.push_back(word(r_a));
                    r_phase = PH_FETCH;
                end
                default: chk_bus("R6", 1'b0, 1'b0, 7'd0, 16'h0);
            endcase
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 128; i++) m[i] = 8'h00;
    endtask

    // Reset, run until the core stops, check cycle count (R10) and the final flags.
    task automatic run_prog(input int exp_cyc, input bit e_done, input bit e_err, input string tag);
        int cnt;
        ref_on = 1'b0;
        rst_n  = 1'b0;
        repeat (2) @(posedge clk);
        r_phase = PH_FETCH; r_pc = '0; stk.delete(); r_done = 1'b0; r_err = 1'b0;
        @(posedge clk);
        #1;
        rst_n  = 1'b1;
        ref_on = 1'b1;
        cnt = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (cnt == 0) begin
                chk(!done && !err && mem_rd && mem_addr == 7'd0, "R1",
                    {61'd0, done, err, mem_rd}, 64'd1);
            end
            if (done || err) break;
            cnt++;
        end
        chk(cnt == exp_cyc, "R10", 64'(cnt), 64'(exp_cyc));
        chk(done == e_done && err == e_err, tag, {62'd0, done, err}, {62'd0, e_done, e_err});
        repeat (3) @(negedge clk);
    endtask

    initial begin : main
        // Full-program run: a0=a1+a2; a1=a0+a2; a2=a0+a1 with a wrapping sum.
        clear_mem();
        put(7'h00, enc(3'd1, 7'h62)); put(7'h02, enc(3'd1, 7'h64)); put(7'h04, enc(3'd3, 7'h00));
        put(7'h06, enc(3'd2, 7'h60)); put(7'h08, enc(3'd1, 7'h60)); put(7'h0A, enc(3'd1, 7'h64));
        put(7'h0C, enc(3'd3, 7'h00)); put(7'h0E, enc(3'd2, 7'h62)); put(7'h10, enc(3'd1, 7'h60));
        put(7'h12, enc(3'd1, 7'h62)); put(7'h14, enc(3'd3, 7'h00)); put(7'h16, enc(3'd2, 7'h64));
        put(7'h60, 16'h1234); put(7'h62, 16'hFFF0); put(7'h64, 16'h0020);
        run_prog(32, 1'b1, 1'b0, "R6");
        chk(word(7'h60) == 16'h0010, "R5", 64'(word(7'h60)), 64'h0010);
        chk(word(7'h62) == 16'h0030, "R4", 64'(word(7'h62)), 64'h0030);
        chk(m[7'h64] == 8'h40 && m[7'h65] == 8'h00, "R2", {48'd0, m[7'h65], m[7'h64]}, 64'h0040);

        // Fill to exactly 8 entries, drain in LIFO order.
        clear_mem();
        for (int i = 0; i < 8; i++) begin
            put(7'(2 * i), enc(3'd1, 7'(8'h70 + 2 * i)));
            put(7'(16 + 2 * i), enc(3'd2, 7'(8'h40 + 2 * i)));
            put(7'(8'h70 + 2 * i), 16'(16'h1000 + i));
        end
        run_prog(42, 1'b1, 1'b0, "R6");
        for (int k = 0; k < 8; k++) begin
            chk(word(7'(8'h40 + 2 * k)) == 16'(16'h1000 + 7 - k), "R4",
                64'(word(7'(8'h40 + 2 * k))), 64'(16'h1000 + 7 - k));
        end

        // Overflow: ninth push.
        clear_mem();
        for (int i = 0; i < 9; i++) put(7'(2 * i), enc(3'd1, 7'h70));
        put(7'h70, 16'h0001);
        run_prog(26, 1'b0, 1'b1, "R7");

        // Underflow on pop: target must stay untouched.
        clear_mem();
        put(7'h00, enc(3'd2, 7'h50)); put(7'h50, 16'hBEEF);
        run_prog(2, 1'b0, 1'b1, "R8");
        chk(word(7'h50) == 16'hBEEF, "R8", 64'(word(7'h50)), 64'hBEEF);

        // Underflow on add with one entry.
        clear_mem();
        put(7'h00, enc(3'd1, 7'h70)); put(7'h02, enc(3'd3, 7'h00));
        run_prog(5, 1'b0, 1'b1, "R8");

        // Malformed words: illegal opcode, reserved bits, odd address.
        clear_mem();
        put(7'h00, enc(3'd5, 7'h00));
        run_prog(2, 1'b0, 1'b1, "R9");
        clear_mem();
        put(7'h00, 16'h20F0);
        run_prog(2, 1'b0, 1'b1, "R9");
        clear_mem();
        put(7'h00, enc(3'd1, 7'h71));
        run_prog(2, 1'b0, 1'b1, "R9");

        // Immediate halt from cleared memory.
        clear_mem();
        run_prog(2, 1'b1, 1'b0, "R6");

        ref_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog R10 actual=%0d expected=<20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end
endmodule